// File: doc/BRIEF.md
# Slot Expansion ROM Window Controller

This block decides when a peripheral card on an 8-bit slot bus may answer in the shared 2 KB expansion window at $C800-$CFFF, and when its private 256-byte slot ROM page is selected. A single ownership flag records whether this card currently owns the window. A slot strobe access sets the flag. Any access to the shared release address $CFFF clears it. The data path and the ROM contents sit outside the block: it only produces the selects, the data-bus drive enable and the 11-bit window offset.

Two static choices shape the policy.

- **Activation source.** The flag can be set by the I/O-select strobe, which marks the slot ROM page. Alternatively, it can be set only by the device-select strobe, which marks the slot's register page. With the second choice, firmware running from slot ROM can drop the window and return without the next opcode fetch taking it back.
- **Release handling.** The release address can be decoded on all 16 bits, or only on the $CFxx page. The card can also be allowed to drive the byte at the release address ("release after read"), or made to stay silent there as the shared convention expects.

Flag changes are committed at the falling edge of the bus phase clock. The release therefore takes effect at the end of the bus cycle that addresses it.

Top module: `exp_window_ctrl`

## Requirements
- R1: While rst_ni is low, and right after reset, win_en_o, win_cs_o and bus_drive_o are 0.
- R2: With act_dev_i=0, a bus cycle with phi_i high and io_sel_ni=0 sets win_en_o when phi_i falls.
- R3: With act_dev_i=1, only a cycle with dev_sel_ni=0 sets win_en_o; a cycle with io_sel_ni=0 leaves it unchanged.
- R4: With clr_full_i=1, only address $CFFF clears win_en_o (a cycle at $CFFE does not). With clr_full_i=0, any address $CF00-$CFFF clears it.
- R5: With rel_read_i=1, a read of the release address while the flag is set gives win_cs_o=1 and bus_drive_o=1 during that cycle, and win_en_o falls only after phi_i falls.
- R6: With rel_read_i=0, win_cs_o and bus_drive_o stay 0 during any cycle whose address matches the release decode.
- R7: win_cs_o=1 only when win_en_o=1, phi_i=1 and addr_i lies in $C800-$CFFF.
- R8: bus_drive_o=1 only when win_cs_o=1 and rw_i=1 (read).
- R9: win_off_o equals addr_i[10:0]. slot_rom_sel_o equals phi_i AND NOT io_sel_ni.
- R10: When a set condition and a clear condition occur in the same bus cycle, win_en_o ends up 0.
- R11: win_en_o changes only in the system clock cycle that follows a falling edge of phi_i.
- R12: act_dev_i, clr_full_i and rel_read_i are captured on the first clock after reset release. Later changes to them have no effect until the next reset.
- R13: With act_dev_i=0, the exit sequence "fetch from slot ROM, read $CFFF, fetch the next opcode from slot ROM" leaves win_en_o set. With act_dev_i=1, the same sequence leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi_i | input | 1 | Bus phase clock; high = address valid phase |
| addr_i | input | 16 | Bus address |
| rw_i | input | 1 | 1 = read, 0 = write |
| io_sel_ni | input | 1 | Slot ROM page strobe, active low |
| dev_sel_ni | input | 1 | Slot register page strobe, active low |
| act_dev_i | input | 1 | 1 = activate on device-select only |
| clr_full_i | input | 1 | 1 = full decode of $CFFF, 0 = whole $CFxx page |
| rel_read_i | input | 1 | 1 = drive the byte at the release address |
| win_en_o | output | 1 | Window ownership flag |
| win_cs_o | output | 1 | Expansion window chip-select |
| bus_drive_o | output | 1 | Data-bus drive enable |
| win_off_o | output | 11 | Offset inside the window |
| slot_rom_sel_o | output | 1 | Slot ROM page select |

## Verification
Activation and release can fall in the same bus cycle. The bench provokes this by asserting the slot strobe while the address is $CFFF. It does so once with the flag clear and once with the flag set, and expects the flag to be clear afterwards in both cases. A second overlap is the release read itself: the window must still respond while the clear is pending. The bench samples the chip-select and drive enable in the middle of the phase, and samples the flag after the phase ends.

// File: rtl/exp_window_pkg.sv
package exp_window_pkg;
  typedef struct packed {
    logic act_dev;   // activate on device-select only
    logic clr_full;  // full 16-bit release decode
    logic rel_read;  // drive the byte at the release address
  } win_cfg_t;
endpackage

// File: rtl/exp_cfg_latch.sv
module exp_cfg_latch
  import exp_window_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  win_cfg_t cfg_i,
  output win_cfg_t cfg_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cfg_o    <= '0;
    end else if (!locked_q) begin
      locked_q <= 1'b1;
      cfg_o    <= cfg_i;
    end
  end
endmodule

// File: rtl/exp_addr_decode.sv
module exp_addr_decode #(
  parameter int          AW       = 16,
  parameter int          OFF_W    = 11,
  parameter int          PAGE_W   = 8,
  parameter logic [15:0] WIN_BASE = 16'hC800,
  parameter logic [15:0] REL_ADDR = 16'hCFFF
) (
  input  logic [AW-1:0] addr_i,
  input  logic          clr_full_i,
  output logic          in_win_o,
  output logic          rel_hit_o
);
  localparam int HI_W = AW - OFF_W;
  localparam int PG_W = AW - PAGE_W;
  localparam logic [AW-1:0] BASE = AW'(WIN_BASE);
  localparam logic [AW-1:0] REL  = AW'(REL_ADDR);

  logic rel_full, rel_page;

  assign in_win_o  = addr_i[AW-1:OFF_W] == BASE[AW-1:OFF_W];
  assign rel_full  = addr_i == REL;
  assign rel_page  = addr_i[AW-1:PAGE_W] == REL[AW-1:PAGE_W];
  assign rel_hit_o = clr_full_i ? rel_full : rel_page;

  if (HI_W < 1 || PG_W < 1) begin : g_bad_width
    initial $display("exp_addr_decode: widths out of range");
  end
endmodule

// File: rtl/exp_own_flag.sv
module exp_own_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic phi_q, set_q, clr_q;

  // conditions gather over the high phase, commit on phase fall, clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi_q  <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      phi_q <= phi_i;
      if (phi_i) begin
        set_q <= set_q | set_i;
        clr_q <= clr_q | clr_i;
      end else if (phi_q) begin
        if (clr_q)      flag_o <= 1'b0;
        else if (set_q) flag_o <= 1'b1;
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exp_window_ctrl.sv
module exp_window_ctrl
  import exp_window_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          OFF_W    = 11,
  parameter logic [15:0] WIN_BASE = 16'hC800,
  parameter logic [15:0] REL_ADDR = 16'hCFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phi_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             rw_i,
  input  logic             io_sel_ni,
  input  logic             dev_sel_ni,
  input  logic             act_dev_i,
  input  logic             clr_full_i,
  input  logic             rel_read_i,
  output logic             win_en_o,
  output logic             win_cs_o,
  output logic             bus_drive_o,
  output logic [OFF_W-1:0] win_off_o,
  output logic             slot_rom_sel_o
);
  win_cfg_t cfg_in, cfg;
  logic in_win, rel_hit, set_c, clr_c, quiet, hit;

  assign cfg_in = '{act_dev: act_dev_i, clr_full: clr_full_i, rel_read: rel_read_i};

  exp_cfg_latch i_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (cfg_in),
    .cfg_o (cfg)
  );

  exp_addr_decode #(
    .AW(AW), .OFF_W(OFF_W), .WIN_BASE(WIN_BASE), .REL_ADDR(REL_ADDR)
  ) i_dec (
    .addr_i    (addr_i),
    .clr_full_i(cfg.clr_full),
    .in_win_o  (in_win),
    .rel_hit_o (rel_hit)
  );

  assign set_c = cfg.act_dev ? !dev_sel_ni : !io_sel_ni;
  assign clr_c = rel_hit;

  exp_own_flag i_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .phi_i (phi_i),
    .set_i (set_c),
    .clr_i (clr_c),
    .flag_o(win_en_o)
  );

  // standard mode: stay off the bus at the shared release address
  assign quiet          = rel_hit && !cfg.rel_read;
  assign hit            = win_en_o && in_win && phi_i && !quiet;
  assign win_cs_o       = hit;
  assign bus_drive_o    = hit && rw_i;
  assign win_off_o      = addr_i[OFF_W-1:0];
  assign slot_rom_sel_o = phi_i && !io_sel_ni;
endmodule

// File: rtl/exp_window_chk.sv
module exp_window_chk #(
  parameter int          AW       = 16,
  parameter int          OFF_W    = 11,
  parameter logic [15:0] WIN_BASE = 16'hC800
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          phi_i,
  input logic [AW-1:0] addr_i,
  input logic          rw_i,
  input logic          io_sel_ni,
  input logic          win_en_o,
  input logic          win_cs_o,
  input logic          bus_drive_o,
  input logic          slot_rom_sel_o
);
  localparam logic [AW-1:0] BASE = AW'(WIN_BASE);
  logic phi_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi_prev <= 1'b0;
    else         phi_prev <= phi_i;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_idle_r1: assert (!win_en_o && !win_cs_o && !bus_drive_o);
  end

  p_cs_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cs_o |-> (win_en_o && phi_i && addr_i[AW-1:OFF_W] == BASE[AW-1:OFF_W]));

  p_drive_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> (win_cs_o && rw_i));

  p_slot_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rom_sel_o |-> (phi_i && !io_sel_ni));

  p_flag_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi_prev && !phi_i) |=> $stable(win_en_o));
endmodule

bind exp_window_ctrl exp_window_chk #(
  .AW(AW), .OFF_W(OFF_W), .WIN_BASE(WIN_BASE)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phi_i         (phi_i),
  .addr_i        (addr_i),
  .rw_i          (rw_i),
  .io_sel_ni     (io_sel_ni),
  .win_en_o      (win_en_o),
  .win_cs_o      (win_cs_o),
  .bus_drive_o   (bus_drive_o),
  .slot_rom_sel_o(slot_rom_sel_o)
);

// File: tb/test_exp_window_ctrl.sv
`timescale 1ns/1ps
module test_exp_window_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, phi = 1'b0, rw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        io_n = 1'b1, dev_n = 1'b1;
  logic        act_dev = 1'b0, clr_full = 1'b1, rel_read = 1'b0;
  logic        en, cs, drv, sel;
  logic [10:0] off;
  logic        m_cs, m_drv, m_en, m_sel;
  logic [10:0] m_off;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  exp_window_ctrl i_exp_window_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .phi_i(phi), .addr_i(addr), .rw_i(rw),
    .io_sel_ni(io_n), .dev_sel_ni(dev_n), .act_dev_i(act_dev),
    .clr_full_i(clr_full), .rel_read_i(rel_read), .win_en_o(en),
    .win_cs_o(cs), .bus_drive_o(drv), .win_off_o(off), .slot_rom_sel_o(sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ad, input logic cf, input logic rr);
    @(negedge clk);
    act_dev = ad; clr_full = cf; rel_read = rr; rst_n = 1'b0;
    phi = 1'b0; io_n = 1'b1; dev_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 en in reset", int'(en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one bus cycle; mid-phase outputs captured into m_*
  task automatic bus(input logic [15:0] a, input logic r, input logic io, input logic dv);
    @(negedge clk);
    addr = a; rw = r; io_n = ~io; dev_n = ~dv; phi = 1'b1;
    repeat (2) @(negedge clk);
    m_cs = cs; m_drv = drv; m_en = en; m_sel = sel; m_off = off;
    phi = 1'b0; io_n = 1'b1; dev_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R1 en", int'(en), 0);
    chk("R1 cs", int'(cs), 0);
    chk("R1 drv", int'(drv), 0);
  endtask

  task automatic t_default_set;
    do_reset(1'b0, 1'b1, 1'b0);
    bus(16'hC812, 1'b1, 1'b0, 1'b0);
    chk("R7 cs before set", int'(m_cs), 0);
    bus(16'hC705, 1'b1, 1'b1, 1'b0);
    chk("R9 slot sel", int'(m_sel), 1);
    chk("R2 set by io", int'(en), 1);
    bus(16'hC812, 1'b1, 1'b0, 1'b0);
    chk("R7 cs in window", int'(m_cs), 1);
    chk("R8 drive on read", int'(m_drv), 1);
    chk("R9 offset", int'(m_off), 'h012);
    chk("R9 no slot sel", int'(m_sel), 0);
    bus(16'hCA34, 1'b0, 1'b0, 1'b0);
    chk("R8 write cs", int'(m_cs), 1);
    chk("R8 no drive on write", int'(m_drv), 0);
    bus(16'h0400, 1'b1, 1'b0, 1'b0);
    chk("R7 outside window", int'(m_cs), 0);
  endtask

  task automatic t_release_std;
    do_reset(1'b0, 1'b1, 1'b0);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    bus(16'hCFFE, 1'b1, 1'b0, 1'b0);
    chk("R4 CFFE keeps flag", int'(en), 1);
    bus(16'hCFFF, 1'b1, 1'b0, 1'b0);
    chk("R6 no cs at CFFF", int'(m_cs), 0);
    chk("R6 no drive at CFFF", int'(m_drv), 0);
    chk("R11 flag held in phase", int'(m_en), 1);
    chk("R4 CFFF clears", int'(en), 0);
  endtask

  task automatic t_release_read;
    do_reset(1'b0, 1'b1, 1'b1);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    bus(16'hCFFF, 1'b1, 1'b0, 1'b0);
    chk("R5 cs at CFFF", int'(m_cs), 1);
    chk("R5 drive at CFFF", int'(m_drv), 1);
    chk("R5 flag held in phase", int'(m_en), 1);
    chk("R5 cleared after phase", int'(en), 0);
  endtask

  task automatic t_coarse;
    do_reset(1'b0, 1'b0, 1'b0);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    bus(16'hCF10, 1'b1, 1'b0, 1'b0);
    chk("R6 coarse quiet", int'(m_cs), 0);
    chk("R4 coarse clears", int'(en), 0);
  endtask

  task automatic t_alt;
    do_reset(1'b1, 1'b1, 1'b0);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    chk("R3 io ignored", int'(en), 0);
    bus(16'hC0F0, 1'b1, 1'b0, 1'b1);
    chk("R3 dev sets", int'(en), 1);
  endtask

  task automatic t_clear_wins;
    do_reset(1'b0, 1'b1, 1'b0);
    bus(16'hCFFF, 1'b1, 1'b1, 1'b0);
    chk("R10 clear wins from 0", int'(en), 0);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    bus(16'hCFFF, 1'b1, 1'b1, 1'b0);
    chk("R10 clear wins from 1", int'(en), 0);
  endtask

  task automatic exit_seq;
    bus(16'hC7F0, 1'b1, 1'b1, 1'b0);
    bus(16'hC7F1, 1'b1, 1'b1, 1'b0);
    bus(16'hC7F2, 1'b1, 1'b1, 1'b0);
    bus(16'hCFFF, 1'b1, 1'b0, 1'b0);
    bus(16'hC7F3, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_exit;
    do_reset(1'b0, 1'b1, 1'b0);
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    exit_seq();
    chk("R13 default re-sets", int'(en), 1);
    do_reset(1'b1, 1'b1, 1'b0);
    bus(16'hC0F0, 1'b1, 1'b0, 1'b1);
    exit_seq();
    chk("R13 alt stays off", int'(en), 0);
  endtask

  task automatic t_cfg_lock;
    do_reset(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    act_dev = 1'b1; rel_read = 1'b1;
    bus(16'hC700, 1'b1, 1'b1, 1'b0);
    chk("R12 mode locked", int'(en), 1);
    bus(16'hCFFF, 1'b1, 1'b0, 1'b0);
    chk("R12 release mode locked", int'(m_cs), 0);
  endtask

  initial begin
    t_reset();
    t_default_set();
    t_release_std();
    t_release_read();
    t_coarse();
    t_alt();
    t_clear_wins();
    t_exit();
    t_cfg_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule